// File: doc/BRIEF.md
# Ping-Pong Serial Line Buffer

This block holds image lines one at a time in two single-bit line memories that trade roles. The writer shifts a line into one memory on its own clock, one bit per enabled edge. At the same time the reader shifts the previous line out of the other memory on an unrelated clock. A rising edge on the swap input exchanges the two memories. The writer can then load the next line while the reader drains the line just finished.

Each memory has its own write position and read position. Either position can be restarted independently: the write side can begin a line again, or the read side can replay a line. Two flags come from the write position. One says that a fresh memory is waiting for data. The other says that the memory is full. After the last stored bit has gone out, the serial output holds a level chosen by an input pin. A chip-select input gates data movement and swaps.

The swap pulse and the two restart inputs pass through two-flop synchronisers into the clock domain that acts on them. The read side takes the swap from the write side through a toggle handshake. Because of this, the line length it picks up is always stable.

Top module: `plb_top`

## Requirements
- R1: While `rst_n` is low and right after it rises, `wr_req` is 1 and `wr_full` is 0. The read line length is zero, so `rd_bit` equals `idle_hi` and enabled reads return `idle_hi`.
- R2: `wr_req` is 1 exactly when the write position is 0. `wr_full` is 1 exactly when the write position equals DEPTH. Both flags are in the `wclk` domain.
- R3: A bit on `wr_bit` is stored, and the write position advances by one, only on a rising `wclk` edge with `cs` and `wr_en` both 1. Bits are stored at addresses 0, 1, 2 and so on, in arrival order.
- R4: The write position saturates at DEPTH. Further enabled writes are ignored and never show up in a later read-out.
- R5: A rising edge of `swap` seen while `cs` is 1 exchanges the memories. It also records the write position as the new read line length, returns the write position to 0 (`wr_req`=1, `wr_full`=0), and restarts the read position.
- R6: After a swap, the k-th enabled read (a rising `rclk` edge with `cs` and `rd_en` both 1, k counting from 0) drives stored bit k onto `rd_bit`, starting at that edge.
- R7: Once the recorded line length has been read out, every later enabled read leaves `rd_bit` at the current `idle_hi` level.
- R8: A line written during the read-out of the previous line does not disturb that read-out. The new line reads back intact after the next swap.
- R9: Holding `wr_clr` high sets the write position to 0 (`wr_req`=1) without touching the read side. Bits written afterwards start again at address 0.
- R10: Holding `rd_clr` high sets the read position to 0 and drives `rd_bit` to `idle_hi`. The next enabled read replays bit 0 of the same line. The write position is unchanged.
- R11: With `cs` low, writes, reads and swap edges have no effect.
- R12: With `rd_en` low, `rd_bit` holds its value across `rclk` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| cs | input | 1 | Chip select; gates writes, reads and swaps |
| wr_en | input | 1 | Write clock enable |
| wr_bit | input | 1 | Serial data in |
| rd_en | input | 1 | Read clock enable |
| rd_bit | output | 1 | Serial data out |
| swap | input | 1 | Memory exchange request, rising-edge active |
| wr_clr | input | 1 | Write position restart, level |
| rd_clr | input | 1 | Read position restart, level |
| idle_hi | input | 1 | Output level once the line is exhausted |
| wr_req | output | 1 | Fresh memory ready for a line |
| wr_full | output | 1 | Write memory full |

## Verification
A write position that is off by one shows up at once in the flags. `wr_req` or `wr_full` would change on the wrong write edge, or fail to change, and the bench samples both flags after those edges. A bank-select or address fault shows up as a wrong bit on `rd_bit` on the first affected enabled read after a swap. A wrong recorded line length shows up as an early or late return to the idle level at the end of the line. Swap and restart faults are caught within a few cycles of each domain. The bench compares every read-out bit and every flag against line models it keeps for itself.

// File: rtl/plb_pkg.sv
package plb_pkg;
  // Write position decode: used by the RTL and restated independently in the bench.
  function automatic logic pos_is_full(input int unsigned pos, input int unsigned depth);
    return pos >= depth;
  endfunction

  function automatic logic pos_is_empty(input int unsigned pos);
    return pos == 0;
  endfunction

  // True while the read position still points inside the captured line.
  function automatic logic pos_in_line(input int unsigned pos, input int unsigned len);
    return pos < len;
  endfunction
endpackage

// File: rtl/plb_sync2.sv
module plb_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/plb_bank_store.sv
module plb_bank_store #(
  parameter int DEPTH  = 5120,
  parameter int WORD_W = 32,
  localparam int WORDS = (DEPTH + WORD_W - 1) / WORD_W,
  localparam int BW    = $clog2(WORD_W),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic          wsel,
  input  logic [CW-1:0] waddr,
  input  logic          wbit,
  input  logic          rsel,
  input  logic [CW-1:0] raddr,
  output logic          rbit
);
  // Word-organised banks keep the element count small; one bit is written per edge.
  logic [WORD_W-1:0] mem [2][WORDS];

  logic [CW-BW-1:0] w_word, r_word;
  logic [BW-1:0]    w_off,  r_off;

  assign w_word = waddr[CW-1:BW];
  assign w_off  = waddr[BW-1:0];
  assign r_word = raddr[CW-1:BW];
  assign r_off  = raddr[BW-1:0];

  always_ff @(posedge wclk) begin
    if (we) mem[wsel][w_word][w_off] <= wbit;
  end

  assign rbit = mem[rsel][r_word][r_off];
endmodule

// File: rtl/plb_wr_side.sv
module plb_wr_side
  import plb_pkg::*;
#(
  parameter int DEPTH = 5120,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr_en,
  input  logic          swap_raw,
  input  logic          clr_raw,
  output logic [CW-1:0] wpos,
  output logic          wsel,
  output logic [CW-1:0] len_q,
  output logic          hand,
  output logic          tog_evt,
  output logic          wr_go,
  output logic          clr_s,
  output logic          wr_req,
  output logic          wr_full
);
  logic sw_s, sw_q;

  plb_sync2 u_sw  (.clk(wclk), .rst_n(rst_n), .d(swap_raw), .q(sw_s));
  plb_sync2 u_clr (.clk(wclk), .rst_n(rst_n), .d(clr_raw),  .q(clr_s));

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= sw_s;
  end

  assign tog_evt = sw_s & ~sw_q & cs;
  assign wr_full = pos_is_full(32'(wpos), DEPTH);
  assign wr_req  = pos_is_empty(32'(wpos));
  assign wr_go   = cs & wr_en & ~wr_full & ~tog_evt & ~clr_s;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wpos  <= '0;
      wsel  <= 1'b0;
      len_q <= '0;
      hand  <= 1'b0;
    end else if (tog_evt) begin
      wsel  <= ~wsel;
      len_q <= wpos;
      wpos  <= '0;
      hand  <= ~hand;
    end else if (clr_s) begin
      wpos  <= '0;
    end else if (wr_go) begin
      wpos  <= wpos + 1'b1;
    end
  end
endmodule

// File: rtl/plb_rd_side.sv
module plb_rd_side
  import plb_pkg::*;
#(
  parameter int DEPTH = 5120,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd_en,
  input  logic          hand,
  input  logic [CW-1:0] len_in,
  input  logic          clr_raw,
  input  logic          idle_hi,
  input  logic          mem_bit,
  output logic          rsel,
  output logic [CW-1:0] rpos,
  output logic [CW-1:0] rlen,
  output logic          rd_evt,
  output logic          clr_s,
  output logic          rd_step,
  output logic          rd_bit
);
  logic hand_s, hand_q, valid, data_q, in_line;

  plb_sync2 u_hand (.clk(rclk), .rst_n(rst_n), .d(hand),    .q(hand_s));
  plb_sync2 u_clr  (.clk(rclk), .rst_n(rst_n), .d(clr_raw), .q(clr_s));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) hand_q <= 1'b0;
    else        hand_q <= hand_s;
  end

  assign rd_evt  = hand_s ^ hand_q;
  assign in_line = pos_in_line(32'(rpos), 32'(rlen));
  assign rd_step = cs & rd_en & ~rd_evt & ~clr_s;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rsel   <= 1'b1;
      rpos   <= '0;
      rlen   <= '0;
      valid  <= 1'b0;
      data_q <= 1'b0;
    end else if (rd_evt) begin
      rsel   <= ~rsel;
      rlen   <= len_in;
      rpos   <= '0;
      valid  <= 1'b0;
    end else if (clr_s) begin
      rpos   <= '0;
      valid  <= 1'b0;
    end else if (rd_step) begin
      if (in_line) begin
        data_q <= mem_bit;
        valid  <= 1'b1;
        rpos   <= rpos + 1'b1;
      end else begin
        valid  <= 1'b0;
      end
    end
  end

  assign rd_bit = valid ? data_q : idle_hi;
endmodule

// File: rtl/plb_top.sv
module plb_top #(
  parameter int DEPTH  = 5120,
  parameter int WORD_W = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic wclk,
  input  logic rclk,
  input  logic rst_n,
  input  logic cs,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  output logic rd_bit,
  input  logic swap,
  input  logic wr_clr,
  input  logic rd_clr,
  input  logic idle_hi,
  output logic wr_req,
  output logic wr_full
);
  logic [CW-1:0] wpos, len_q, rpos, rlen;
  logic wsel, rsel, hand, tog_evt, wr_go, wclr_s, rd_evt, rclr_s, rd_step, mem_bit;

  plb_wr_side #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en),
    .swap_raw(swap), .clr_raw(wr_clr),
    .wpos(wpos), .wsel(wsel), .len_q(len_q), .hand(hand),
    .tog_evt(tog_evt), .wr_go(wr_go), .clr_s(wclr_s),
    .wr_req(wr_req), .wr_full(wr_full)
  );

  plb_bank_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
    .wclk(wclk), .we(wr_go), .wsel(wsel), .waddr(wpos), .wbit(wr_bit),
    .rsel(rsel), .raddr(rpos), .rbit(mem_bit)
  );

  plb_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .cs(cs), .rd_en(rd_en),
    .hand(hand), .len_in(len_q), .clr_raw(rd_clr), .idle_hi(idle_hi),
    .mem_bit(mem_bit), .rsel(rsel), .rpos(rpos), .rlen(rlen),
    .rd_evt(rd_evt), .clr_s(rclr_s), .rd_step(rd_step), .rd_bit(rd_bit)
  );
endmodule

// File: rtl/plb_chk.sv
module plb_chk #(
  parameter int DEPTH = 5120,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic [CW-1:0] wpos,
  input logic          wr_go,
  input logic          tog_evt,
  input logic          wclr_s,
  input logic          wr_req,
  input logic          wr_full,
  input logic [CW-1:0] rpos,
  input logic [CW-1:0] rlen,
  input logic          rd_evt,
  input logic          rclr_s
);
  a_r3_step_one: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_go |=> (wpos == $past(wpos) + 1'b1));

  a_r4_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    wpos <= CW'(DEPTH));

  a_r4_full_holds: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_full && !tog_evt && !wclr_s) |=> wr_full);

  a_r5_swap_restart: assert property (@(posedge wclk) disable iff (!rst_n)
    tog_evt |=> (wr_req && !wr_full));

  a_r2_flags_exclusive: assert property (@(posedge wclk) disable iff (!rst_n)
    !(wr_req && wr_full));

  a_r6_read_bounded: assert property (@(posedge rclk) disable iff (!rst_n)
    rpos <= rlen);

  a_r10_read_restart: assert property (@(posedge rclk) disable iff (!rst_n)
    (rclr_s && !rd_evt) |=> (rpos == '0));

  a_r9_write_restart: assert property (@(posedge wclk) disable iff (!rst_n)
    (wclr_s && !tog_evt) |=> wr_req);
endmodule

bind plb_top plb_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
  .wpos(wpos), .wr_go(wr_go), .tog_evt(tog_evt), .wclr_s(wclr_s),
  .wr_req(wr_req), .wr_full(wr_full),
  .rpos(rpos), .rlen(rlen), .rd_evt(rd_evt), .rclr_s(rclr_s)
);

// File: tb/tb_plb_top.sv
module tb_plb_top;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH       = 320;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic cs = 1, wr_en = 0, wr_bit = 0, rd_en = 0, swap = 0, wr_clr = 0, rd_clr = 0, idle_hi = 1;
  logic rd_bit, wr_req, wr_full;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit line_a [DEPTH+3];
  bit line_b [100];
  bit line_c [40];
  bit got    [DEPTH];

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  plb_top #(.DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_en(rd_en), .rd_bit(rd_bit), .swap(swap), .wr_clr(wr_clr), .rd_clr(rd_clr),
    .idle_hi(idle_hi), .wr_req(wr_req), .wr_full(wr_full)
  );

  // Bench restatement of the flag rules from the write count it keeps itself.
  function automatic bit exp_req(int n);  return n == 0;      endfunction
  function automatic bit exp_full(int n); return n >= DEPTH;  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_one(input bit b);
    @(negedge wclk); wr_en = 1; wr_bit = b;
    @(posedge wclk); #1 wr_en = 0;
  endtask

  task automatic rd_one(output bit b);
    @(negedge rclk); rd_en = 1;
    @(posedge rclk); #1 rd_en = 0; b = rd_bit;
  endtask

  task automatic do_swap();
    @(negedge wclk); swap = 1;
    repeat (4) @(negedge wclk);
    swap = 0;
    repeat (3) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  // Reads n bits with random idle gaps; counts gap cycles where the output moved.
  task automatic read_line(input int n, output int moved);
    bit b, held;
    moved = 0;
    for (int i = 0; i < n; i++) begin
      if ($urandom % 4 == 0) begin
        @(negedge rclk); held = rd_bit;
        @(negedge rclk); if (rd_bit != held) moved++;
      end
      rd_one(b);
      got[i] = b;
    end
  endtask

  initial begin
    int moved, bad, first;
    bit b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH + 3; i++) line_a[i] = 1'($urandom);
    for (int i = 0; i < 100; i++) line_b[i] = 1'($urandom);
    for (int i = 0; i < 40; i++) line_c[i] = 1'($urandom);

    repeat (3) @(negedge wclk);
    // R1: reset state
    check(wr_req == 1 && wr_full == 0, "R1 flags in reset", {wr_req, wr_full}, 2);
    rst_n = 1;
    repeat (3) @(negedge rclk);
    check(rd_bit == 1, "R1 idle high after reset", rd_bit, 1);
    idle_hi = 0; #1;
    check(rd_bit == 0, "R1 idle low after reset", rd_bit, 0);
    rd_one(b);
    check(b == 0, "R1 empty read gives idle", b, 0);
    idle_hi = 1;

    // R3/R2: first bit clears the request flag
    wr_one(line_a[0]);
    @(negedge wclk);
    check(wr_req == exp_req(1) && wr_full == exp_full(1), "R2 flags after one write", {wr_req, wr_full}, 0);
    // R3: enable low does not advance
    @(negedge wclk); wr_bit = 1; repeat (3) @(negedge wclk);
    for (int i = 1; i < DEPTH - 1; i++) wr_one(line_a[i]);
    @(negedge wclk);
    check(wr_full == exp_full(DEPTH - 1), "R2 not full one short", wr_full, 0);
    wr_one(line_a[DEPTH-1]);
    @(negedge wclk);
    check(wr_full == exp_full(DEPTH) && wr_req == 0, "R2 full at depth", wr_full, 1);
    // R4: extra writes ignored
    for (int i = DEPTH; i < DEPTH + 3; i++) wr_one(line_a[i]);
    @(negedge wclk);
    check(wr_full == 1, "R4 full saturates", wr_full, 1);

    do_swap();
    @(negedge wclk);
    check(wr_req == 1 && wr_full == 0, "R5 flags after swap", {wr_req, wr_full}, 2);

    // R8: write line B while reading line A
    fork
      begin
        for (int i = 0; i < 100; i++) begin
          if ($urandom % 3 == 0) @(negedge wclk);
          wr_one(line_b[i]);
        end
      end
      read_line(DEPTH, moved);
    join
    bad = 0; first = -1;
    for (int i = 0; i < DEPTH; i++) if (got[i] != line_a[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, "R6 line A bit order", first, -1);
    check(moved == 0, "R12 output holds with read enable low", moved, 0);
    // R7: idle after end, both levels
    rd_one(b); check(b == 1, "R7 idle high after line", b, 1);
    idle_hi = 0; rd_one(b); check(b == 0, "R7 idle low after line", b, 0);
    idle_hi = 1;

    // R10: replay from bit 0, write side untouched
    @(negedge rclk); rd_clr = 1; repeat (4) @(negedge rclk); rd_clr = 0; repeat (3) @(negedge rclk);
    check(rd_bit == 1, "R10 idle after read restart", rd_bit, 1);
    bad = 0;
    for (int i = 0; i < 5; i++) begin rd_one(b); if (b != line_a[i]) bad++; end
    check(bad == 0, "R10 replay first bits", bad, 0);
    @(negedge wclk);
    check(wr_req == exp_req(100) && wr_full == 0, "R10 write count kept", wr_req, 0);

    // R9: write restart, then line C overwrites from address 0
    @(negedge wclk); wr_clr = 1; repeat (4) @(negedge wclk); wr_clr = 0; repeat (3) @(negedge wclk);
    check(wr_req == 1, "R9 request after write restart", wr_req, 1);
    for (int i = 0; i < 40; i++) wr_one(line_c[i]);
    do_swap();
    read_line(40, moved);
    bad = 0; first = -1;
    for (int i = 0; i < 40; i++) if (got[i] != line_c[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, "R9 line C after restart", first, -1);
    check(moved == 0, "R12 hold during line C", moved, 0);
    idle_hi = 0; rd_one(b);
    check(b == 0, "R7 line length from restart", b, 0);
    idle_hi = 1;

    // R11: chip select low blocks reads, writes and swap
    @(negedge rclk); rd_clr = 1; repeat (4) @(negedge rclk); rd_clr = 0; repeat (3) @(negedge rclk);
    cs = 0;
    for (int i = 0; i < 3; i++) wr_one(1'b1);
    @(negedge wclk);
    check(wr_req == 1, "R11 write ignored", wr_req, 1);
    for (int i = 0; i < 3; i++) begin rd_one(b); end
    check(b == 1, "R11 read ignored", b, 1);
    do_swap();
    cs = 1;
    rd_one(b);
    check(b == line_c[0], "R11 swap ignored", b, line_c[0]);
    rd_one(b);
    check(b == line_c[1], "R6 second bit after hold", b, line_c[1]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule